// File: doc/BRIEF.md
# Rendering Coprocessor Control Register Block

This block is the host-facing register set of a small vector rendering coprocessor. A 32-bit word bus reads and writes the control/status word, the latched error word, two page-bound limits, a plane mask, an 8-bit raster-op code, a queue overflow counter, a diagnostics bit, a read-only identity word, an R0 preset and a soft-reset strobe. A write to the instruction-push address places a word in an internal instruction queue. The execution datapath takes that word from a valid/acknowledge port, and only while the run bit is set.

A 128-entry, 32-bit register file can be reached in two ways. Direct writes are taken only while the engine is stopped. Queued writes enter the instruction queue as pseudo-instructions, and the block applies them itself when they reach the head of the queue during run. The whole map is repeated in a second window in which the page-bound limits cannot be written. Error classes come from the bus side (rejected pushes, queue overflow, blocked direct writes) and from a report port of the datapath. They are latched in the error word and raise one interrupt line.

The bus uses word addresses. Address bit 10 selects the mirror window. Bits 9:0 hold the byte offset shifted right by two, so byte offset 0x100 is word 0x40 and the mirror base 0x1000 is word 0x400.

Top module: `render_csr`

## Requirements
- R1: After reset, the control word (byte 0x00) reads 0x00008000, the error word (0x04) reads 0, irq and ins_valid are 0, and the ID word (0x28) reads {CHIP_REV in bits 15:8, ARCH_CODE in bits 7:0}.
- R2: Control word fields: bits 5:0 are class enables, bit 7 is the interrupt enable, bit 12 is page-check enable and bit 14 is run, all read/write. Bit 15 is read-only and reads 1 exactly when the queue is empty. Bit 13 is set by an eng_wrote pulse and cleared by writing 1 to it.
- R3: A word written to 0x20 is queued. ins_valid is raised only while run=1, and words leave in push order, one per cycle in which ins_valid and ins_ack are both high.
- R4: A push whose bits 31:28 equal 4'h8 (memory class) is dropped while diagnostics bit 0 (0x1C) is 0 and raises error class 0. With that bit at 1 it is queued normally.
- R5: A push or queued write into a full queue (QDEPTH entries) is dropped. It increments the counter at 0x18 and raises error class 5. Any write to 0x18 clears the counter.
- R6: A write to 0x100+4*r while stopped stores into entry r, and the same address reads that entry back. While running, the write is dropped and raises error class 3.
- R7: A write to 0x300+4*r queues a pseudo-instruction. It is applied to entry r when it reaches the head of the queue while running, it is never shown on ins_valid, and it keeps its order relative to pushed instructions.
- R8: An error class n is latched into error-word bit n only if control bit n is set. Writing 1 to error-word bit n clears it. Error-word bit 7 reads the interrupt state.
- R9: irq is high exactly when interrupt enable (control bit 7) is set and at least one error bit is latched.
- R10: Any write to 0x30 empties the queue, clears all error bits and the run bit, and copies the R0 preset (0x2C, read/write) into register-file entry 0.
- R11: In the mirror window (offset + 0x1000) every register behaves as in the base window, except that writes to the page bounds (0x08, 0x0C) are ignored.
- R12: Plane mask (0x10), page bounds and the raster-op code (0x14, bits 7:0, upper bits read 0) read back as written and drive their output ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_waddr | input | 11 | Word address; bit 10 selects the mirror window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| bus_rvalid | output | 1 | Read data valid |
| ins_valid | output | 1 | Queued instruction offered to the datapath |
| ins_word | output | 32 | Offered instruction word |
| ins_ack | input | 1 | Datapath takes the offered word |
| eng_err | input | 6 | Error class pulses from the datapath |
| eng_wrote | input | 1 | Pulse: the engine performed a memory write |
| irq | output | 1 | Error interrupt |
| run | output | 1 | Run bit |
| pb_check | output | 1 | Page-bound checking enable |
| page_lo | output | 32 | Lower page bound |
| page_hi | output | 32 | Upper page bound |
| plane_mask | output | 32 | Plane mask |
| rop_code | output | 8 | Raster-op code |

## Verification
Assertions check on every cycle that the queue count never exceeds its depth, that the datapath is offered a word only while running, that a full-queue push adds exactly one to the overflow counter, that a blocked direct write latches class 3, that a soft reset leaves run, queue and errors cleared, and that irq never rises without the interrupt enable. The bench scenarios are needed for the rest. They show instruction order and the interleaving of pseudo-instructions with real ones, register-file contents after blocked and accepted writes, the mirror window's read-only page bounds, class masking, write-1-to-clear and the R0 preset copy.

// File: rtl/render_csr.sv
module render_csr #(
  parameter int          QDEPTH    = 8,
  parameter logic [7:0]  ARCH_CODE = 8'h01,
  parameter logic [7:0]  CHIP_REV  = 8'h03
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [10:0] bus_waddr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        ins_valid,
  output logic [31:0] ins_word,
  input  logic        ins_ack,
  input  logic [5:0]  eng_err,
  input  logic        eng_wrote,
  output logic        irq,
  output logic        run,
  output logic        pb_check,
  output logic [31:0] page_lo,
  output logic [31:0] page_hi,
  output logic [31:0] plane_mask,
  output logic [7:0]  rop_code
);
  localparam int QAW  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int NREG = 128;
  localparam logic [9:0] A_CTRL = 10'd0,  A_ERR = 10'd1,  A_PBL  = 10'd2,  A_PBH = 10'd3;
  localparam logic [9:0] A_PM   = 10'd4,  A_ROP = 10'd5,  A_OVF  = 10'd6,  A_DIAG = 10'd7;
  localparam logic [9:0] A_INS  = 10'd8,  A_ID  = 10'd10, A_R0I  = 10'd11, A_SRST = 10'd12;
  localparam logic [9:0] A_DIR  = 10'd64, A_QUE = 10'd192, A_END = 10'd320;
  localparam logic [QAW:0] QFULL = (QAW+1)'(QDEPTH);

  logic [9:0] off;
  logic       mir;
  assign off = bus_waddr[9:0];
  assign mir = bus_waddr[10];

  logic       in_dir, in_que;
  logic [6:0] dir_idx, que_idx;
  assign in_dir  = (off >= A_DIR) && (off < A_QUE);
  assign in_que  = (off >= A_QUE) && (off < A_END);
  assign dir_idx = 7'(off - A_DIR);
  assign que_idx = 7'(off - A_QUE);

  logic [5:0]  ee_q, err_q;
  logic        ei_q, pb_q, wo_q, go_q, diag_q;
  logic [31:0] pbl_q, pbh_q, pm_q, ovf_q, r0i_q;
  logic [7:0]  rop_q;

  logic w_ctrl, w_err, w_ovf, w_ins, w_srst;
  assign w_ctrl = bus_wr && off == A_CTRL;
  assign w_err  = bus_wr && off == A_ERR;
  assign w_ovf  = bus_wr && off == A_OVF;
  assign w_ins  = bus_wr && off == A_INS;
  assign w_srst = bus_wr && off == A_SRST;

  logic is_mem, rej_mem, w_dir, dir_ok, dir_bad, w_que, push_req;
  assign is_mem   = bus_wdata[31:28] == 4'h8;
  assign rej_mem  = w_ins && is_mem && !diag_q;
  assign w_dir    = bus_wr && in_dir;
  assign dir_ok   = w_dir && !go_q;
  assign dir_bad  = w_dir && go_q;
  assign w_que    = bus_wr && in_que;
  assign push_req = (w_ins && !rej_mem) || w_que;

  logic [31:0]    q_data [QDEPTH];
  logic [6:0]     q_idx  [QDEPTH];
  logic           q_ps   [QDEPTH];
  logic [QAW-1:0] wp, rp;
  logic [QAW:0]   cnt;
  logic           full, hv, push, pseudo_pop, pop;

  assign full       = cnt == QFULL;
  assign hv         = cnt != '0;
  assign push       = push_req && !full;
  assign ins_valid  = go_q && hv && !q_ps[rp];
  assign ins_word   = q_data[rp];
  assign pseudo_pop = go_q && hv && q_ps[rp];
  assign pop        = pseudo_pop || (ins_valid && ins_ack);

  function automatic logic [QAW-1:0] bump(input logic [QAW-1:0] p);
    return (p == QAW'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (w_srst) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      cnt <= cnt + {{QAW{1'b0}}, push} - {{QAW{1'b0}}, pop};
    end

  always_ff @(posedge clk)
    if (push) begin
      q_data[wp] <= bus_wdata;
      q_idx[wp]  <= que_idx;
      q_ps[wp]   <= w_que;
    end

  logic [31:0] rf [NREG];
  always_ff @(posedge clk)
    if (w_srst)          rf[0]         <= r0i_q;
    else if (dir_ok)     rf[dir_idx]   <= bus_wdata;
    else if (pseudo_pop) rf[q_idx[rp]] <= q_data[rp];

  logic [5:0] new_err, err_clr;
  assign new_err = eng_err | {push_req && full, 1'b0, dir_bad, 2'b00, rej_mem};
  assign err_clr = w_err ? bus_wdata[5:0] : 6'd0;
  assign irq     = ei_q && (err_q != 6'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ee_q <= '0; ei_q <= 1'b0; pb_q <= 1'b0; wo_q <= 1'b0; go_q <= 1'b0;
      err_q <= '0; pbl_q <= '0; pbh_q <= '0; pm_q <= '0; rop_q <= '0;
      ovf_q <= '0; diag_q <= 1'b0; r0i_q <= '0;
    end else begin
      if (w_ctrl) begin
        ee_q <= bus_wdata[5:0];
        ei_q <= bus_wdata[7];
        pb_q <= bus_wdata[12];
      end
      if (w_srst)      go_q <= 1'b0;
      else if (w_ctrl) go_q <= bus_wdata[14];
      wo_q  <= (wo_q && !(w_ctrl && bus_wdata[13])) || eng_wrote;
      err_q <= w_srst ? 6'd0 : ((err_q & ~err_clr) | (new_err & ee_q));
      if (bus_wr && off == A_PBL && !mir) pbl_q <= bus_wdata;
      if (bus_wr && off == A_PBH && !mir) pbh_q <= bus_wdata;
      if (bus_wr && off == A_PM)   pm_q   <= bus_wdata;
      if (bus_wr && off == A_ROP)  rop_q  <= bus_wdata[7:0];
      if (bus_wr && off == A_DIAG) diag_q <= bus_wdata[0];
      if (bus_wr && off == A_R0I)  r0i_q  <= bus_wdata;
      if (w_ovf)                 ovf_q <= '0;
      else if (push_req && full) ovf_q <= ovf_q + 32'd1;
    end

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    case (off)
      A_CTRL: rd_val = {16'd0, !hv, go_q, wo_q, pb_q, 4'd0, ei_q, 1'b0, ee_q};
      A_ERR:  rd_val = {24'd0, irq, 1'b0, err_q};
      A_PBL:  rd_val = pbl_q;
      A_PBH:  rd_val = pbh_q;
      A_PM:   rd_val = pm_q;
      A_ROP:  rd_val = {24'd0, rop_q};
      A_OVF:  rd_val = ovf_q;
      A_DIAG: rd_val = {31'd0, diag_q};
      A_ID:   rd_val = {16'd0, CHIP_REV, ARCH_CODE};
      A_R0I:  rd_val = r0i_q;
      default:
        if (in_dir)      rd_val = rf[dir_idx];
        else if (in_que) rd_val = rf[que_idx];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bus_rdata <= '0; bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_val;
    end

  assign run        = go_q;
  assign pb_check   = pb_q;
  assign page_lo    = pbl_q;
  assign page_hi    = pbh_q;
  assign plane_mask = pm_q;
  assign rop_code   = rop_q;

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= QFULL);
  assert_ovf_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !w_ovf) |=> ovf_q == $past(ovf_q) + 32'd1);
  assert_offer_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> run);
  assert_direct_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_bad && ee_q[3]) |=> err_q[3]);
  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    w_srst |=> (!go_q && cnt == '0 && err_q == 6'd0));
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ei_q);
endmodule

// File: tb/test_render_csr.sv
module test_render_csr;
  localparam int CLK_P = 10;
  localparam int QD = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [10:0] bus_waddr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, ins_ack = 1'b0, eng_wrote = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [5:0]  eng_err = '0;
  logic [31:0] bus_rdata, ins_word, page_lo, page_hi, plane_mask;
  logic        bus_rvalid, ins_valid, irq, run, pb_check;
  logic [7:0]  rop_code;

  render_csr #(.QDEPTH(QD), .ARCH_CODE(8'h01), .CHIP_REV(8'h03)) i_render_csr (
    .clk(clk), .rst_n(rst_n), .bus_waddr(bus_waddr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ins_valid(ins_valid), .ins_word(ins_word), .ins_ack(ins_ack), .eng_err(eng_err),
    .eng_wrote(eng_wrote), .irq(irq), .run(run), .pb_check(pb_check), .page_lo(page_lo),
    .page_hi(page_hi), .plane_mask(plane_mask), .rop_code(rop_code));

  always #(CLK_P/2) clk = ~clk;

  int vectors = 0, misses = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (bus_rvalid) begin
      if (exp_q.size() == 0) chk("unexpected read data", bus_rdata, 32'hx);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end

  task automatic wr(logic [12:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_waddr = a[12:2]; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [12:0] a, logic [31:0] e, string tag);
    @(negedge clk); bus_rd = 1'b1; bus_waddr = a[12:2];
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic take(logic [31:0] e, string tag);
    @(negedge clk);
    chk({tag, " valid"}, {31'd0, ins_valid}, 32'd1);
    chk({tag, " word"}, ins_word, e);
    ins_ack = 1'b1;
    @(negedge clk); ins_ack = 1'b0;
  endtask

  task automatic pulse_err(logic [5:0] v);
    @(negedge clk); eng_err = v;
    @(negedge clk); eng_err = '0;
  endtask

  task automatic scenario;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(13'h00, 32'h0000_8000, "R1 ctrl reset");
    rd(13'h04, 32'h0, "R1 err reset");
    rd(13'h28, 32'h0000_0301, "R1 id");
    chk("R1 irq reset", {31'd0, irq}, 0);
    chk("R1 ins_valid reset", {31'd0, ins_valid}, 0);

    wr(13'h10, 32'hA5A5_0F0F);
    wr(13'h14, 32'h0000_01FF);
    rd(13'h10, 32'hA5A5_0F0F, "R12 plane mask");
    rd(13'h14, 32'h0000_00FF, "R12 rop width");
    chk("R12 plane port", plane_mask, 32'hA5A5_0F0F);
    chk("R12 rop port", {24'd0, rop_code}, 32'hFF);

    wr(13'h08, 32'h1000_0000);
    wr(13'h0C, 32'h2000_0000);
    wr(13'h1008, 32'h0000_DEAD);
    rd(13'h1008, 32'h1000_0000, "R11 mirror page_lo read-only");
    chk("R11 page_lo port", page_lo, 32'h1000_0000);
    chk("R12 page_hi port", page_hi, 32'h2000_0000);
    wr(13'h1010, 32'h0000_FFFF);
    rd(13'h10, 32'h0000_FFFF, "R11 mirror plane mask writable");

    wr(13'h114, 32'h0000_1234);
    wr(13'h2FC, 32'hFEED_0127);
    rd(13'h114, 32'h0000_1234, "R6 direct write r5");
    rd(13'h2FC, 32'hFEED_0127, "R6 direct write r127");

    wr(13'h00, 32'h0000_10BF);
    chk("R2 pb_check", {31'd0, pb_check}, 1);
    wr(13'h00, 32'h0000_40BF);
    chk("R2 run port", {31'd0, run}, 1);
    wr(13'h114, 32'h0000_9999);
    rd(13'h114, 32'h0000_1234, "R6 direct write dropped while running");
    rd(13'h04, 32'h0000_0088, "R8 class 3 latched");
    chk("R9 irq set", {31'd0, irq}, 1);
    wr(13'h04, 32'h0000_0008);
    rd(13'h04, 32'h0, "R8 write-1-to-clear");
    chk("R9 irq cleared", {31'd0, irq}, 0);

    wr(13'h00, 32'h0000_00BF);
    wr(13'h20, 32'hA000_0001);
    wr(13'h20, 32'hA000_0002);
    wr(13'h20, 32'hB000_0003);
    rd(13'h00, 32'h0000_00BF, "R2 queue not empty");
    chk("R3 no offer while stopped", {31'd0, ins_valid}, 0);
    wr(13'h00, 32'h0000_40BF);
    take(32'hA000_0001, "R3 first");
    take(32'hA000_0002, "R3 second");
    take(32'hB000_0003, "R3 third");
    rd(13'h00, 32'h0000_C0BF, "R2 queue empty again");

    wr(13'h20, 32'h8000_0010);
    chk("R4 memory push dropped", {31'd0, ins_valid}, 0);
    rd(13'h04, 32'h0000_0081, "R4 class 0 latched");
    wr(13'h04, 32'h0000_0001);
    wr(13'h1C, 32'h1);
    wr(13'h20, 32'h8000_0010);
    take(32'h8000_0010, "R4 memory push allowed");
    wr(13'h1C, 32'h0);

    wr(13'h00, 32'h0000_00BF);
    for (int i = 0; i < QD; i++) wr(13'h20, 32'hA000_0100 + i);
    wr(13'h20, 32'hA000_0FFF);
    rd(13'h18, 32'h1, "R5 overflow counted");
    rd(13'h04, 32'h0000_00A0, "R5 class 5 latched");
    wr(13'h18, 32'h0);
    rd(13'h18, 32'h0, "R5 counter cleared");
    wr(13'h30, 32'h0);
    rd(13'h00, 32'h0000_80BF, "R10 soft reset clears run and queue");
    rd(13'h04, 32'h0, "R10 soft reset clears errors");

    wr(13'h124, 32'h0000_0011);
    wr(13'h324, 32'h0000_0077);
    wr(13'h20, 32'hA000_0009);
    wr(13'h328, 32'h0000_0055);
    rd(13'h124, 32'h0000_0011, "R7 pseudo write held while stopped");
    wr(13'h00, 32'h0000_40BF);
    take(32'hA000_0009, "R7 real instruction after pseudo");
    repeat (2) @(negedge clk);
    chk("R7 pseudo not offered", {31'd0, ins_valid}, 0);
    rd(13'h124, 32'h0000_0077, "R7 pseudo applied r9");
    rd(13'h128, 32'h0000_0055, "R7 pseudo applied r10");

    wr(13'h00, 32'h0000_00BF);
    wr(13'h2C, 32'h0000_CAFE);
    rd(13'h2C, 32'h0000_CAFE, "R10 preset readback");
    wr(13'h30, 32'h0);
    rd(13'h100, 32'h0000_CAFE, "R10 preset copied to r0");

    wr(13'h00, 32'h0000_4080);
    wr(13'h114, 32'h0000_5555);
    rd(13'h04, 32'h0, "R8 disabled class not latched");
    wr(13'h00, 32'h0000_4084);
    pulse_err(6'h01);
    rd(13'h04, 32'h0, "R8 masked engine error");
    pulse_err(6'h04);
    rd(13'h04, 32'h0000_0084, "R8 engine class 2 latched");
    chk("R9 irq from engine error", {31'd0, irq}, 1);
    wr(13'h04, 32'h0000_0004);
    chk("R9 irq after clear", {31'd0, irq}, 0);

    @(negedge clk); eng_wrote = 1'b1;
    @(negedge clk); eng_wrote = 1'b0;
    rd(13'h00, 32'h0000_E084, "R2 wrote flag set");
    wr(13'h00, 32'h0000_2084);
    rd(13'h00, 32'h0000_8084, "R2 wrote flag cleared");
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      scenario();
      begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) chk("pending reads", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule